// File: doc/BRIEF.md
# Gated Edge Timestamp Channel

This block watches one asynchronous digital input and, while a software-controlled gate is open, records its transitions. When the gate is opened, a two-bit selector is captured. It chooses rising transitions, falling transitions, or both. In stamp mode, every selected transition is tagged with the value of a free-running 64-bit coarse cycle counter and written into a bounded event queue. A host pops the queue through a show-ahead read port. At most one event enters the queue per clock cycle.

An alternative count mode does not store stamps. It adds up the selected transitions, one per cycle at most. When the gate closes, the total is written into the queue as one entry and the tally restarts from zero. If an event arrives while the queue is full, the event is discarded and a sticky overflow flag is raised beside the read data. The flag stays up until the host clears it.

A gate controller is built around four named states:
- `GS_IDLE`: gate closed.
- `GS_STAMP`: gate open, timestamping.
- `GS_COUNT`: gate open, counting.
- `GS_FLUSH`: one cycle that writes the final tally.

Transitions:
- `GS_IDLE`→`GS_STAMP` on an open command with count mode low.
- `GS_IDLE`→`GS_COUNT` on an open command with count mode high.
- `GS_STAMP`→`GS_IDLE` on a close command.
- `GS_COUNT`→`GS_FLUSH` on a close command.
- `GS_FLUSH`→`GS_IDLE` unconditionally.

Top module: `edge_stamp_chan`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low), `rd_ovf` is low and `gate_active` is low.
- R2: `pin_in` passes through a two-flop synchronizer followed by one previous-sample flop. The coarse counter is 0 in the first cycle after reset release and advances by one per clock edge. A transition applied before clock edge k is stamped with the counter value held between edges k+1 and k+2. The entry becomes readable after edge k+2.
- R3: `gate_sel` is captured on the open command. Bit 0 set selects rising transitions, bit 1 set selects falling transitions, and 2'b11 selects both.
- R4: Open and close commands change `gate_active` at the next clock edge. Transitions seen while the gate is closed produce no queue entry.
- R5: Transitions detected in consecutive cycles each produce one entry. Entries are read back in detection order.
- R6: The queue holds DEPTH entries (default 64). An event that finds the queue full, with no pop in the same cycle, is discarded and the stored entries are kept.
- R7: A discarded event sets `rd_ovf`. The flag stays high until an `ovf_clr` pulse. If a discard and a clear happen in the same cycle, the flag is set.
- R8: In count mode, closing the gate writes the number of selected transitions, zero-extended, as one entry one cycle after the close edge. The next count session starts from zero.
- R9: `rd_data` shows the oldest entry whenever `rd_valid` is high. `rd_en` pops that entry. `rd_en` on an empty queue has no effect.
- R10: An open command while the gate is already open is ignored. The captured mode and selector are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Coarse clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous monitored signal |
| gate_open | input | 1 | Open command pulse |
| gate_close | input | 1 | Close command pulse |
| gate_sel | input | 2 | Transition selector, bit 0 rising, bit 1 falling |
| count_mode | input | 1 | Count mode selected at open when high |
| rd_en | input | 1 | Pop the oldest entry |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 64 | Oldest entry: stamp or final tally |
| rd_ovf | output | 1 | Sticky overflow flag |
| gate_active | output | 1 | Gate is open |

## Verification
The bench targets the two-cycle synchronizer latency. A design with one flop too few or too many would return every stamp one count off. It fills the queue past its depth: a design that overwrites instead of discarding would return newer stamps, and one that forgets the flag would leave `rd_ovf` low after the drain. Count sessions are run back to back, so a tally that is not cleared at close shows up as an inflated second count. Re-opening an already open gate with different settings would change which transitions get recorded if the controller accepted it. Random sessions with mixed selectors, modes and gaps are compared against a bench model of the selector and the counter.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_STAMP = 2'd1,
        GS_COUNT = 2'd2,
        GS_FLUSH = 2'd3
    } gate_state_t;

    localparam int SEL_RISE_BIT = 0;
    localparam int SEL_FALL_BIT = 1;
endpackage

// File: rtl/es_sync_edge.sv
module es_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    // chain[SYNC_STAGES-1] is the synchronized sample, chain[SYNC_STAGES] the previous one
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_in;
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

    // R2: a single sample pair cannot be both a rising and a falling transition
    p_edge_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
endmodule

// File: rtl/es_gate_fsm.sv
module es_gate_fsm
    import edge_stamp_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_open,
    input  logic            gate_close,
    input  logic [1:0]      gate_sel,
    input  logic            count_mode,
    input  logic            rise,
    input  logic            fall,
    input  logic [TS_W-1:0] ts,
    output logic            push,
    output logic [TS_W-1:0] push_data,
    output logic            active
);
    gate_state_t state_q, state_d;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] tally_q;
    logic             hit;

    assign hit = (rise & sel_q[SEL_RISE_BIT]) | (fall & sel_q[SEL_FALL_BIT]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE:  if (gate_open) state_d = count_mode ? GS_COUNT : GS_STAMP;
            GS_STAMP: if (gate_close) state_d = GS_IDLE;
            GS_COUNT: if (gate_close) state_d = GS_FLUSH;
            GS_FLUSH: state_d = GS_IDLE;
            default:  state_d = GS_IDLE;
        endcase
    end

    // selector capture and tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 2'b00;
            tally_q <= '0;
        end else begin
            if (state_q == GS_IDLE && gate_open) sel_q <= gate_sel;
            if (state_q == GS_FLUSH)             tally_q <= '0;
            else if (state_q == GS_COUNT && hit) tally_q <= tally_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        push      = 1'b0;
        push_data = ts;
        active    = 1'b0;
        unique case (state_q)
            GS_IDLE: ;
            GS_STAMP: begin
                active = 1'b1;
                push   = hit;
            end
            GS_COUNT: active = 1'b1;
            GS_FLUSH: begin
                push      = 1'b1;
                push_data = TS_W'(tally_q);
            end
            default: ;
        endcase
    end

    // R4: nothing is written while the gate is closed
    p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_IDLE) |-> !push);
    // R8: flush lasts one cycle and leaves the tally at zero
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_FLUSH) |=> (state_q == GS_IDLE && tally_q == '0));
    // R10: an open gate stays in its mode until a close arrives
    p_stamp_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_STAMP && !gate_close) |=> (state_q == GS_STAMP));
    p_count_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_COUNT && !gate_close) |=> (state_q == GS_COUNT && $stable(sel_q)));
endmodule

// File: rtl/es_event_fifo.sv
module es_event_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             ovf_clr,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    level;
    logic             full, do_pop, do_push, drop;

    assign full    = (level == LW'(DEPTH));
    assign do_pop  = rd_en && (level != '0);
    assign do_push = wr_en && (!full || do_pop);
    assign drop    = wr_en && !do_push;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign rd_valid = (level != '0);
    assign rd_data  = mem[rd_ptr];

    // R6: occupancy never exceeds the depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R7: a write into a full queue with no pop raises the flag
    p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> ovf);
    // R7: the flag only falls on a clear
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    // R9: popping an empty queue leaves it empty
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_en && !wr_en) |=> !rd_valid);
endmodule

// File: rtl/edge_stamp_chan.sv
module edge_stamp_chan
    import edge_stamp_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_in,
    input  logic            gate_open,
    input  logic            gate_close,
    input  logic [1:0]      gate_sel,
    input  logic            count_mode,
    input  logic            rd_en,
    input  logic            ovf_clr,
    output logic            rd_valid,
    output logic [TS_W-1:0] rd_data,
    output logic            rd_ovf,
    output logic            gate_active
);
    logic [TS_W-1:0] ts_q;
    logic            rise, fall, push;
    logic [TS_W-1:0] push_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    es_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    es_gate_fsm #(.TS_W(TS_W), .CNT_W(TS_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .gate_close(gate_close),
        .gate_sel(gate_sel), .count_mode(count_mode), .rise(rise), .fall(fall),
        .ts(ts_q), .push(push), .push_data(push_data), .active(gate_active)
    );

    es_event_fifo #(.WIDTH(TS_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_data),
        .rd_en(rd_en), .ovf_clr(ovf_clr), .rd_valid(rd_valid),
        .rd_data(rd_data), .ovf(rd_ovf)
    );

    // R2: the coarse counter advances by exactly one per cycle
    p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_q != '1) |=> (ts_q == $past(ts_q) + 1'b1));
endmodule

// File: tb/tb_edge_stamp_chan.sv
module tb_edge_stamp_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, gate_open = 1'b0, gate_close = 1'b0;
    logic [1:0]  gate_sel = 2'b00;
    logic        count_mode = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
    logic        rd_valid, rd_ovf, gate_active;
    logic [63:0] rd_data;

    int unsigned n_chk = 0, n_bad = 0;
    logic [63:0] bcnt = 64'd0;
    logic [63:0] expq[$];
    bit          m_open = 0, m_cnt = 0;
    logic [1:0]  m_sel = 2'b00;
    longint unsigned m_tally = 0;

    edge_stamp_chan dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gate_open(gate_open),
        .gate_close(gate_close), .gate_sel(gate_sel), .count_mode(count_mode),
        .rd_en(rd_en), .ovf_clr(ovf_clr), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ovf(rd_ovf), .gate_active(gate_active)
    );

    always #2 clk = ~clk;

    always @(posedge clk) bcnt <= rst_n ? bcnt + 64'd1 : 64'd0;

    function automatic bit sel_match(input logic [1:0] sel, input logic newlvl);
        return newlvl ? sel[0] : sel[1];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic toggle();
        pin_in = ~pin_in;
        if (m_open && sel_match(m_sel, pin_in)) begin
            if (m_cnt) m_tally++;
            else if (expq.size() < 64) expq.push_back(bcnt + 64'd2);
        end
        @(negedge clk);
    endtask

    task automatic open_gate(input logic [1:0] sel, input bit cm);
        gate_sel = sel; count_mode = cm; gate_open = 1'b1;
        if (!m_open) begin
            chk(gate_active == 1'b0, "R4", gate_active, 0);
            m_open = 1; m_cnt = cm; m_sel = sel; m_tally = 0;
        end
        @(negedge clk);
        gate_open = 1'b0;
        chk(gate_active == 1'b1, "R4", gate_active, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic close_gate();
        repeat (3) @(negedge clk);
        gate_close = 1'b1;
        @(negedge clk);
        gate_close = 1'b0;
        chk(gate_active == 1'b0, "R4", gate_active, 0);
        if (m_cnt) expq.push_back(64'(m_tally));
        m_open = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input string req);
        while (expq.size() > 0) begin
            logic [63:0] e;
            e = expq.pop_front();
            chk(rd_valid == 1'b1, req, rd_valid, 1);
            chk(rd_data == e, req, rd_data, e);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(rd_valid == 1'b0, "R9", rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_valid == 0, "R1", rd_valid, 0);
        chk(rd_ovf == 0, "R1", rd_ovf, 0);
        chk(gate_active == 0, "R1", gate_active, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 closed gate records nothing
        repeat (6) toggle();
        repeat (4) @(negedge clk);
        chk(rd_valid == 0, "R4", rd_valid, 0);

        // R9 pop on empty has no effect, then R2 single stamp latency
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk(rd_valid == 0, "R9", rd_valid, 0);
        open_gate(2'b01, 0);
        if (pin_in) toggle();
        toggle();
        close_gate();
        drain("R2");

        // R5 back-to-back edges, both polarities, R3
        open_gate(2'b11, 0);
        repeat (10) toggle();
        close_gate();
        drain("R5");

        // R3 falling only
        open_gate(2'b10, 0);
        repeat (8) toggle();
        close_gate();
        drain("R3");

        // R10 re-open ignored
        open_gate(2'b01, 0);
        open_gate(2'b10, 1);
        repeat (6) toggle();
        close_gate();
        drain("R10");

        // R8 two count sessions back to back
        open_gate(2'b11, 1);
        repeat (13) toggle();
        close_gate();
        open_gate(2'b01, 1);
        repeat (9) toggle();
        close_gate();
        drain("R8");

        // R6/R7 overflow
        open_gate(2'b11, 0);
        repeat (70) toggle();
        close_gate();
        chk(rd_ovf == 1, "R7", rd_ovf, 1);
        drain("R6");
        chk(rd_ovf == 1, "R7", rd_ovf, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk(rd_ovf == 0, "R7", rd_ovf, 0);

        // random sessions
        for (int s = 0; s < 12; s++) begin
            logic [1:0] sel;
            bit cm;
            int n;
            sel = 2'($urandom_range(1, 3));
            cm  = 1'($urandom_range(0, 1));
            n   = int'($urandom_range(3, 30));
            open_gate(sel, cm);
            for (int k = 0; k < n; k++) begin
                toggle();
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
            close_gate();
            drain(cm ? "R8" : "R5");
        end
        chk(rd_ovf == 0, "R7", rd_ovf, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule